// File: doc/BRIEF.md
# Data Access Alignment and Stack Window Checker

This block sits in front of a load/store unit and inspects every data access before it reaches memory. For each access it receives the effective address, the access size, whether the access is a store, the number of the register that supplies or receives the data, and a flag marking the access as stack-pointer relative. It applies two tests. The first rejects half-word and word accesses whose address is not a multiple of the access size. The second rejects stack-relative accesses that fall outside a programmable stack window.

When a test fails, the block records the faulting address and a packed cause word in two capture registers. It also raises a one-cycle trap request toward the core. An alignment fault raises the trap only while the exception-enable bit is set, but its address and cause word are captured either way. A stack-window fault always raises the trap. The window limits and the exception-enable bit are loaded through a small write port.

Top module: `mem_access_guard`

## Requirements
- R1: After reset, fault_addr and fault_status are zero, trap_req is low, the low stack limit is zero, the high stack limit is all ones and exception-enable is clear.
- R2: An access is misaligned when addr[0] is set for a half-word (acc_size 2'b01), or when addr[1:0] is nonzero for a word (acc_size 2'b10 or 2'b11). A byte access (acc_size 2'b00) is never misaligned.
- R3: A misaligned access captures its address in fault_addr and sets fault_status as follows: bits 4:0 = 5'h01, bits 9:5 = acc_reg, bit 10 = acc_store, bit 11 = 1 for a word access. All higher bits are zero.
- R4: A misaligned access raises trap_req only when exception-enable is set. When it is clear, the address and status are still captured.
- R5: A stack-relative access (acc_stack = 1) violates when its address is below the low limit or above the high limit, using unsigned comparison. An address equal to either limit is legal. Accesses with acc_stack = 0 are never window-checked.
- R6: A stack violation captures the address, sets fault_status to 5'h07 in bits 4:0 with all other bits zero, and raises trap_req whatever the exception-enable bit is.
- R7: When one access is both misaligned and a stack violation, only the alignment fault is reported: the R3 status is captured and the trap follows R4.
- R8: fault_addr and fault_status keep their values across idle cycles and across accesses that have no fault.
- R9: When cfg_we is high, cfg_sel selects the target: 2'b00 loads the low limit from cfg_wdata, 2'b01 loads the high limit, 2'b10 loads exception-enable from cfg_wdata[0], and 2'b11 changes nothing. The new value applies to accesses in later cycles.
- R10: trap_req is high for exactly the one cycle after the clock edge that samples a trapping access, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Effective address |
| acc_size | input | 2 | 00 byte, 01 half-word, 10/11 word |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| acc_reg | input | 5 | Data register number |
| acc_stack | input | 1 | Access is stack-pointer relative |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_wdata | input | ADDR_W | Configuration write data |
| fault_addr | output | ADDR_W | Address of the last faulting access |
| fault_status | output | STAT_W | Packed cause word of the last fault |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The hardest case to reach from the ports is an access that fails both tests at once while exception-enable is clear. In that case the trap must stay low even though a stack fault alone would always raise it. The bench places the window limits and then drives misaligned stack-relative addresses just past each limit, with exception-enable both clear and set. Random accesses are also clustered within a few bytes of each limit and mixed with exception-enable writes, so the inclusive limit boundaries and the priority rule are hit many times under all sizes.

// File: rtl/mag_pkg.sv
`timescale 1ns/1ps
package mag_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    CFG_LO   = 2'b00,
    CFG_HI   = 2'b01,
    CFG_EE   = 2'b10,
    CFG_NONE = 2'b11
  } cfg_sel_e;

  localparam int CAUSE_W      = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_ALIGN = 5'h01;
  localparam logic [CAUSE_W-1:0] CAUSE_STACK = 5'h07;

  localparam int REG_LSB      = 5;
  localparam int REG_W        = 5;
  localparam int STORE_BIT    = 10;
  localparam int WORD_BIT     = 11;
  localparam int STAT_MIN_W   = 12;

endpackage

// File: rtl/mag_align_check.sv
`timescale 1ns/1ps
module mag_align_check
  import mag_pkg::*;
(
  input  logic [1:0] addr_lo,
  input  logic [1:0] size,
  output logic       misalign,
  output logic       word_sz
);

  logic [1:0] size_mask;

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE: size_mask = 2'b00;
      SZ_HALF: size_mask = 2'b01;
      default: size_mask = 2'b11;
    endcase
  end

  assign misalign = |(addr_lo & size_mask);
  assign word_sz  = &size_mask;

  // R2: a misaligned flag always has a nonzero low address bit behind it
  always_comb begin
    assert_misalign_needs_low_bits_R2: assert (!(misalign === 1'b1) || (addr_lo != 2'b00));
  end

endmodule

// File: rtl/mag_stack_window.sv
`timescale 1ns/1ps
module mag_stack_window
  import mag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              acc_stack,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              stack_viol,
  output logic              exc_en
);

  logic [ADDR_W-1:0] lo_q, lo_d;
  logic [ADDR_W-1:0] hi_q, hi_d;
  logic              ee_q, ee_d;
  logic              lo_le, hi_le, ee_le;

  // load enables
  always_comb begin
    lo_le = cfg_we && (cfg_sel_e'(cfg_sel) == CFG_LO);
    hi_le = cfg_we && (cfg_sel_e'(cfg_sel) == CFG_HI);
    ee_le = cfg_we && (cfg_sel_e'(cfg_sel) == CFG_EE);
  end

  // next state
  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    ee_d = ee_q;
    if (lo_le) lo_d = cfg_wdata;
    if (hi_le) hi_d = cfg_wdata;
    if (ee_le) ee_d = cfg_wdata[0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '1;
      ee_q <= 1'b0;
    end else begin
      if (lo_le) lo_q <= lo_d;
      if (hi_le) hi_q <= hi_d;
      if (ee_le) ee_q <= ee_d;
    end
  end

  always_comb begin
    stack_viol = acc_stack && ((acc_addr < lo_q) || (acc_addr > hi_q));
  end

  assign exc_en = ee_q;

  // R9: a write with the reserved select leaves every setting untouched
  assert_reserved_sel_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'b11) |=> ($stable(lo_q) && $stable(hi_q) && $stable(ee_q)));

  // R9: a low-limit write lands exactly the written data
  assert_lo_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'b00) |=> (lo_q == $past(cfg_wdata)));

  // R5: an access with the stack flag clear never reports a window fault
  assert_nonstack_unchecked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_stack |-> !stack_viol);

endmodule

// File: rtl/mag_fault_capture.sv
`timescale 1ns/1ps
module mag_fault_capture
  import mag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_store,
  input  logic [REG_W-1:0]  acc_reg,
  input  logic              misalign,
  input  logic              word_sz,
  input  logic              stack_viol,
  input  logic              exc_en,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [STAT_W-1:0] fault_status,
  output logic              trap_req
);

  logic              align_hit;
  logic              stack_hit;
  logic              cap_le;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [STAT_W-1:0] stat_d, stat_q;
  logic              trap_d, trap_q;

  // alignment wins over the window test
  always_comb begin
    align_hit = acc_valid && misalign;
    stack_hit = acc_valid && stack_viol && !misalign;
    cap_le    = align_hit || stack_hit;
  end

  // next state
  always_comb begin
    addr_d = acc_addr;
    stat_d = '0;
    if (align_hit) begin
      stat_d[CAUSE_W-1:0]             = CAUSE_ALIGN;
      stat_d[REG_LSB +: REG_W]        = acc_reg;
      stat_d[STORE_BIT]               = acc_store;
      stat_d[WORD_BIT]                = word_sz;
    end else begin
      stat_d[CAUSE_W-1:0]             = CAUSE_STACK;
    end
    trap_d = (align_hit && exc_en) || stack_hit;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      stat_q <= '0;
      trap_q <= 1'b0;
    end else begin
      if (cap_le) begin
        addr_q <= addr_d;
        stat_q <= stat_d;
      end
      trap_q <= trap_d;
    end
  end

  assign fault_addr   = addr_q;
  assign fault_status = stat_q;
  assign trap_req     = trap_q;

  // R8: capture registers hold when no faulting access was sampled
  assert_hold_without_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && (misalign || stack_viol)) |=> ($stable(addr_q) && $stable(stat_q)));

  // R4: alignment fault with exceptions disabled never traps
  assert_ee_gates_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && misalign && !exc_en) |=> !trap_req);

  // R6: a pure window fault always traps
  assert_stack_always_traps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && stack_viol && !misalign) |=> trap_req);

  // R10: no trap follows a cycle without an access
  assert_trap_needs_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !trap_req);

  // R3: the cause field only ever holds one of the defined codes or zero
  assert_cause_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_status[CAUSE_W-1:0] == 5'h00) || (fault_status[CAUSE_W-1:0] == CAUSE_ALIGN)
      || (fault_status[CAUSE_W-1:0] == CAUSE_STACK));

  initial begin
    assert_stat_width_R3: assert (STAT_W >= STAT_MIN_W);
  end

endmodule

// File: rtl/mem_access_guard.sv
`timescale 1ns/1ps
module mem_access_guard
  import mag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic              acc_store,
  input  logic [4:0]        acc_reg,
  input  logic              acc_stack,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [STAT_W-1:0] fault_status,
  output logic              trap_req
);

  logic misalign;
  logic word_sz;
  logic stack_viol;
  logic exc_en;

  mag_align_check u_align (
    .addr_lo  (acc_addr[1:0]),
    .size     (acc_size),
    .misalign (misalign),
    .word_sz  (word_sz)
  );

  mag_stack_window #(
    .ADDR_W (ADDR_W)
  ) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .acc_stack  (acc_stack),
    .acc_addr   (acc_addr),
    .stack_viol (stack_viol),
    .exc_en     (exc_en)
  );

  mag_fault_capture #(
    .ADDR_W (ADDR_W),
    .STAT_W (STAT_W)
  ) u_capture (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_addr     (acc_addr),
    .acc_store    (acc_store),
    .acc_reg      (acc_reg),
    .misalign     (misalign),
    .word_sz      (word_sz),
    .stack_viol   (stack_viol),
    .exc_en       (exc_en),
    .fault_addr   (fault_addr),
    .fault_status (fault_status),
    .trap_req     (trap_req)
  );

endmodule

// File: tb/mem_access_guard_tb_top.sv
`timescale 1ns/1ps
module mem_access_guard_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          acc_valid;
  logic [AW-1:0] acc_addr;
  logic [1:0]    acc_size;
  logic          acc_store;
  logic [4:0]    acc_reg;
  logic          acc_stack;
  logic          cfg_we;
  logic [1:0]    cfg_sel;
  logic [AW-1:0] cfg_wdata;
  logic [AW-1:0] fault_addr;
  logic [SW-1:0] fault_status;
  logic          trap_req;

  int n_checks = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench model state
  logic [AW-1:0] m_lo, m_hi, m_addr;
  logic [SW-1:0] m_stat;
  logic          m_ee, m_trap;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_access_guard #(.ADDR_W(AW), .STAT_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
    .acc_store(acc_store), .acc_reg(acc_reg), .acc_stack(acc_stack),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .fault_addr(fault_addr), .fault_status(fault_status), .trap_req(trap_req)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " fault_addr"}, 64'(fault_addr), 64'(m_addr));
    check({tag, " fault_status"}, 64'(fault_status), 64'(m_stat));
    check({tag, " trap_req R10"}, 64'(trap_req), 64'(m_trap));
  endtask

  function automatic logic exp_misalign(input logic [AW-1:0] a, input logic [1:0] sz);
    if (sz == 2'b00) return 1'b0;
    if (sz == 2'b01) return a[0];
    return a[1:0] != 2'b00;
  endfunction

  function automatic logic [SW-1:0] exp_align_stat(input logic [1:0] sz, input logic st,
                                                   input logic [4:0] rg);
    logic [SW-1:0] s;
    s = '0;
    s[4:0] = 5'h01;
    s[9:5] = rg;
    s[10]  = st;
    s[11]  = sz[1];
    return s;
  endfunction

  task automatic access(input logic [AW-1:0] a, input logic [1:0] sz, input logic st,
                        input logic [4:0] rg, input logic stk, input string tag);
    logic mis, sv;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_store = st;
    acc_reg = rg; acc_stack = stk; cfg_we = 1'b0;
    mis = exp_misalign(a, sz);
    sv  = stk && ((a < m_lo) || (a > m_hi));
    @(posedge clk);
    if (mis) begin
      m_addr = a; m_stat = exp_align_stat(sz, st, rg); m_trap = m_ee;
    end else if (sv) begin
      m_addr = a; m_stat = SW'(32'h7); m_trap = 1'b1;
    end else begin
      m_trap = 1'b0;
    end
    #1;
    check_all(tag);
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    acc_valid = 1'b0; cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk);
    case (sel)
      2'b00: m_lo = d;
      2'b01: m_hi = d;
      2'b10: m_ee = d[0];
      default: ;
    endcase
    m_trap = 1'b0;
    #1;
    check_all("R9 cfg cycle");
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    acc_valid = 1'b0; cfg_we = 1'b0;
    @(posedge clk);
    m_trap = 1'b0;
    #1;
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    acc_valid = 0; acc_addr = '0; acc_size = 0; acc_store = 0; acc_reg = 0;
    acc_stack = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = '0;
    m_lo = '0; m_hi = '1; m_ee = 1'b0; m_addr = '0; m_stat = '0; m_trap = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset fault_addr", 64'(fault_addr), 64'h0);
    check("R1 reset fault_status", 64'(fault_status), 64'h0);
    check("R1 reset trap_req", 64'(trap_req), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset window covers every address, exceptions off
    access(32'h0000_0000, 2'b10, 1'b0, 5'd1, 1'b1, "R1 low limit zero");
    access(32'hFFFF_FFFC, 2'b10, 1'b1, 5'd2, 1'b1, "R1 high limit ones");
    access(32'h0000_0003, 2'b01, 1'b0, 5'd4, 1'b0, "R1 R4 ee clear after reset");
    check("R1 R4 no trap with ee clear", 64'(trap_req), 64'h0);

    cfg_write(2'b00, 32'h0000_1000);
    cfg_write(2'b01, 32'h0000_1FFF);

    // R5 inclusive limits
    access(32'h0000_1000, 2'b10, 1'b0, 5'd3, 1'b1, "R5 at low limit");
    access(32'h0000_1FFC, 2'b10, 1'b0, 5'd3, 1'b1, "R5 word at top");
    access(32'h0000_1FFF, 2'b00, 1'b0, 5'd3, 1'b1, "R5 at high limit");
    // R6 violations with ee clear still trap
    access(32'h0000_2000, 2'b00, 1'b1, 5'd9, 1'b1, "R6 above high");
    check("R6 status value", 64'(fault_status), 64'h7);
    access(32'h0000_0FFF, 2'b00, 1'b0, 5'd9, 1'b1, "R6 below low");
    // R5 non-stack access outside window is unchecked; R8 hold
    access(32'h0000_0000, 2'b00, 1'b0, 5'd9, 1'b0, "R5 R8 nonstack outside");
    check("R8 hold addr", 64'(fault_addr), 64'h0FFF);
    idle("R8 R10 idle hold");
    // R2 R3 R4 half store, ee clear
    access(32'h0000_0003, 2'b01, 1'b1, 5'd17, 1'b0, "R3 R4 half store");
    check("R3 half store status", 64'(fault_status), 64'h621);
    access(32'h0000_0002, 2'b01, 1'b0, 5'd5, 1'b0, "R2 half aligned");
    access(32'h0000_0001, 2'b00, 1'b0, 5'd5, 1'b0, "R2 byte never misaligned");
    cfg_write(2'b10, 32'h1);
    access(32'h0000_0006, 2'b10, 1'b0, 5'd3, 1'b0, "R3 R4 word load ee set");
    check("R3 word load status", 64'(fault_status), 64'h861);
    check("R4 trap with ee set", 64'(trap_req), 64'h1);
    access(32'h0000_0005, 2'b11, 1'b1, 5'd31, 1'b0, "R2 size 11 is word");
    idle("R10 trap drops");
    // R7 priority
    access(32'h0000_2002, 2'b10, 1'b1, 5'd12, 1'b1, "R7 both faults ee set");
    cfg_write(2'b10, 32'h0);
    access(32'h0000_0FFD, 2'b01, 1'b0, 5'd12, 1'b1, "R7 both faults ee clear");
    check("R7 no trap when align wins", 64'(trap_req), 64'h0);
    // R9 reserved select
    cfg_write(2'b11, 32'h0000_0000);
    access(32'h0000_0FFF, 2'b00, 1'b0, 5'd1, 1'b1, "R9 reserved sel ignored low");
    access(32'h0000_1FFF, 2'b00, 1'b0, 5'd1, 1'b1, "R9 reserved sel ignored high");

    // constrained random
    for (int i = 0; i < 600; i++) begin
      int r;
      logic [AW-1:0] a;
      r = int'($urandom % 12);
      if (r == 0) begin
        cfg_write(2'b10, AW'($urandom % 2));
      end else if (r == 1) begin
        idle("R8 R10 random idle");
      end else begin
        case ($urandom % 4)
          0: a = 32'h0000_1000 + AW'($urandom % 9) - 32'd4;
          1: a = 32'h0000_1FFF + AW'($urandom % 9) - 32'd4;
          2: a = AW'($urandom);
          default: a = 32'h0000_1000 + AW'($urandom % 32'h1000);
        endcase
        access(a, 2'($urandom % 4), 1'($urandom % 2), 5'($urandom % 32),
               1'($urandom % 2), "R2 R5 R7 random");
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule